// File: doc/BRIEF.md
# Latched Status Interrupt Controller

This block gathers line-condition levels and one-cycle event pulses into four 8-bit status registers. Each status bit belongs to one of two kinds. An event bit records a momentary occurrence. A condition bit tracks a persistent network state and records a chosen transition of that state. A condition bit can record the rising edge, the falling edge, or both edges. A paired bit records the falling edge of a condition whose rising edge is recorded by a partner bit four positions lower in the same register.

Once a status bit is latched, it holds until the host writes a one to that exact bit. This lets software poll and clear one bit without touching its neighbours. An 8-bit mask sits beside each status register. A summary register tells the host which of the four status registers has an unmasked bit set. A single active-low interrupt output is driven from that summary. A separate live information register shows synchronized levels with no latching and never interrupts.

The host uses a synchronous write strobe and a combinational read path. The read data follows the address in the same cycle.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset, every status register, every mask register and the summary register read 0, and `irq_no` is 1.
- R2: A rise-mode condition bit sets on the third rising clock edge after its input goes high. Two of those edges are spent in the synchronizer and one in edge detection. Register 3 at 0x16 is all rise-mode.
- R3: In register 2 at 0x15, bits 0-3 latch when condition inputs 8-11 rise. Bits 4-7 latch when the same inputs 8-11 fall, which signals that the condition has ended.
- R4: The bits of register 1 at 0x14 latch on both the rising and the falling edge of condition inputs 0-7.
- R5: The bits of register 4 at 0x17 are event bits. A one-cycle pulse on `evt_i[24+n]` sets bit n at the next clock edge.
- R6: Writing to a status register clears each bit written as 1. Bits written as 0 keep their value.
- R7: When a latching edge or pulse arrives in the same cycle as a clear of that bit, the bit stays set.
- R8: Mask registers sit at 0x18-0x1B, one per status register, and read back as written. The summary at 0x13 has bit n = OR over (status n+1 AND mask n+1). Summary bits 4-7 always read 0.
- R9: `irq_no` is 0 exactly when some summary bit is 1.
- R10: The information register at 0x12 reads `info_i` delayed by two clock edges. It does not latch, it ignores writes, and it never affects `irq_no`.
- R11: A latched bit whose condition level stays constant does not set again after being cleared. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 32 | Asynchronous condition levels, register r uses bits 8r+7..8r |
| evt_i | input | 32 | Synchronous one-cycle event pulses, same layout |
| info_i | input | 8 | Asynchronous live levels shown at 0x12 |
| addr_i | input | 8 | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Each condition mode is driven with isolated level steps. This separates rise, fall and double-edge latching, and it confirms that a steady level does not set a bit again. Event bits are driven with single-cycle pulses, alone and in the same cycle as a clear of the same bit, which tells set-priority apart from clear-priority. Clears are written with mixed one and zero patterns to show that only the written ones act. Masks are opened one register at a time, so the summary position identifies which register is interrupting. A behavioural model compares the read data and `irq_no` on every clock.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  typedef enum logic [1:0] {
    MODE_EVT  = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2,
    MODE_BOTH = 2'd3
  } bit_mode_e;

  localparam int ADDR_INFO  = 'h12;
  localparam int ADDR_SUM   = 'h13;
  localparam int ADDR_STAT0 = 'h14;
  localparam int ADDR_MASK0 = 'h18;
endpackage

// File: rtl/cond_sync.sv
module cond_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/stat_reg.sv
module stat_reg
  import stat_irq_pkg::*;
#(
  parameter int             W    = 8,
  parameter logic [2*W-1:0] MODE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] prev_q, stat_q, set_w;

  always_comb begin
    for (int b = 0; b < W; b++) begin
      case (bit_mode_e'(MODE[2*b +: 2]))
        MODE_EVT:  set_w[b] = evt_i[b];
        MODE_RISE: set_w[b] = lvl_i[b] & ~prev_q[b];
        MODE_FALL: set_w[b] = ~lvl_i[b] & prev_q[b];
        default:   set_w[b] = lvl_i[b] ^ prev_q[b];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // set wins over a same-cycle clear
      stat_q <= (stat_q & ~clr_i) | set_w;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_sum.sv
module irq_sum #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] stat_i,
  input  logic [NUM_REGS-1:0][REG_W-1:0] mask_i,
  output logic [NUM_REGS-1:0]            sum_o,
  output logic                           irq_no
);
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) sum_o[r] = |(stat_i[r] & mask_i[r]);
  end

  assign irq_no = ~|sum_o;
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 8,
  parameter logic [2*NUM_REGS*REG_W-1:0] MODE =
    {16'h0000, 16'h5555, 16'hAA55, 16'hFFFF},
  parameter logic [NUM_REGS*REG_W-1:0]   PAIR = 32'h0000_F000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REGS*REG_W-1:0] cond_i,
  input  logic [NUM_REGS*REG_W-1:0] evt_i,
  input  logic [REG_W-1:0]          info_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic                      irq_no
);
  localparam int NBITS = NUM_REGS * REG_W;
  localparam int HALF  = REG_W / 2;

  logic [NBITS-1:0]                cond_s, src_lvl;
  logic [REG_W-1:0]                info_s;
  logic [NUM_REGS-1:0][REG_W-1:0]  stat_q, mask_q, clr_w;
  logic [NUM_REGS-1:0]             sum_w;

  cond_sync #(.W(NBITS)) u_cond_sync (
    .clk_i, .rst_ni, .d_i(cond_i), .q_o(cond_s)
  );

  cond_sync #(.W(REG_W)) u_info_sync (
    .clk_i, .rst_ni, .d_i(info_i), .q_o(info_s)
  );

  // paired bits follow the partner condition in the lower half
  always_comb begin
    for (int i = 0; i < NBITS; i++) begin
      if (PAIR[i] && (i % REG_W) >= HALF) src_lvl[i] = cond_s[i-HALF];
      else                                src_lvl[i] = cond_s[i];
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(ADDR_STAT0 + r);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(ADDR_MASK0 + r);

    assign clr_w[r] = (we_i && addr_i == STAT_A) ? wdata_i : '0;

    stat_reg #(
      .W   (REG_W),
      .MODE(MODE[r*2*REG_W +: 2*REG_W])
    ) u_stat (
      .clk_i,
      .rst_ni,
      .lvl_i (src_lvl[r*REG_W +: REG_W]),
      .evt_i (evt_i[r*REG_W +: REG_W]),
      .clr_i (clr_w[r]),
      .stat_o(stat_q[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mask_q[r] <= '0;
      else if (we_i && addr_i == MASK_A) mask_q[r] <= wdata_i;
    end
  end

  irq_sum #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_irq_sum (
    .stat_i(stat_q), .mask_i(mask_q), .sum_o(sum_w), .irq_no(irq_no)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_INFO)) rdata_o = info_s;
    if (addr_i == ADDR_W'(ADDR_SUM))  rdata_o[NUM_REGS-1:0] = sum_w;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr_i == ADDR_W'(ADDR_STAT0 + r)) rdata_o = stat_q[r];
      if (addr_i == ADDR_W'(ADDR_MASK0 + r)) rdata_o = mask_q[r];
    end
  end
endmodule

// File: rtl/stat_irq_chk.sv
module stat_irq_chk
  import stat_irq_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  parameter int ADDR_W   = 8,
  parameter logic [2*NUM_REGS*REG_W-1:0] MODE = '0
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [NUM_REGS*REG_W-1:0]      evt_i,
  input logic [NUM_REGS-1:0][REG_W-1:0] stat_i,
  input logic [NUM_REGS-1:0][REG_W-1:0] mask_i,
  input logic [REG_W-1:0]               rdata_o,
  input logic                           irq_no
);
  logic [NUM_REGS*REG_W-1:0] stat_flat;
  assign stat_flat = stat_i;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_r
    // R6
    stat_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      |($past(stat_i[r]) & ~stat_i[r]) |-> $past(we_i && addr_i == ADDR_W'(ADDR_STAT0 + r)));
    // R8
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == ADDR_W'(ADDR_MASK0 + r)) |=> $stable(mask_i[r]));
  end

  for (genvar i = 0; i < NUM_REGS*REG_W; i++) begin : g_b
    if (MODE[2*i +: 2] == 2'(MODE_EVT)) begin : g_evt
      // R5
      evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> stat_flat[i]);
    end
  end

  // R9
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == ((stat_i & mask_i) == '0));

  // R8
  sum_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(ADDR_SUM) |-> rdata_o[REG_W-1:NUM_REGS] == '0);
endmodule

bind stat_irq_ctrl stat_irq_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_W(ADDR_W), .MODE(MODE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .evt_i  (evt_i),
  .stat_i (stat_q),
  .mask_i (mask_q),
  .rdata_o(rdata_o),
  .irq_no (irq_no)
);

// File: tb/sim_stat_irq_ctrl.sv
module sim_stat_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] cond = '0, evt = '0;
  logic [7:0]  info = '0, addr = '0, wdata = '0, rdata;
  logic        we = 0, irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  stat_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .evt_i(evt), .info_i(info),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit   m_d1[32], m_d2[32], m_prev[32];
  logic [7:0] m_i1, m_i2;
  logic [7:0] m_stat[4], m_mask[4];

  function automatic int mode_of(int r, int b);
    case (r)
      0: return 3;                    // both edges
      1: return (b < 4) ? 1 : 2;      // rise / paired fall
      2: return 1;                    // rise
      default: return 0;              // event
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_d1[i]) begin m_d1[i] = 0; m_d2[i] = 0; m_prev[i] = 0; end
      m_i1 = '0; m_i2 = '0;
      foreach (m_stat[r]) begin m_stat[r] = '0; m_mask[r] = '0; end
    end else begin
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < 8; b++) begin
          int src;
          bit cur, old, set, clr;
          src = (r == 1 && b >= 4) ? r*8 + b - 4 : r*8 + b;
          cur = m_d2[src];
          old = m_prev[src];
          case (mode_of(r, b))
            0: set = evt[r*8+b];
            1: set = cur && !old;
            2: set = !cur && old;
            default: set = cur != old;
          endcase
          clr = we && addr == 8'(8'h14 + r) && wdata[b];
          if (clr) m_stat[r][b] = 1'b0;
          if (set) m_stat[r][b] = 1'b1;
        end
        if (we && addr == 8'(8'h18 + r)) m_mask[r] = wdata;
      end
      for (int i = 0; i < 32; i++) begin
        m_prev[i] = m_d2[i]; m_d2[i] = m_d1[i]; m_d1[i] = cond[i];
      end
      m_i2 = m_i1; m_i1 = info;
    end
  end

  function automatic logic [7:0] m_sum();
    logic [7:0] s = '0;
    for (int r = 0; r < 4; r++) s[r] = (m_stat[r] & m_mask[r]) != 0;
    return s;
  endfunction

  function automatic logic [7:0] m_rd(logic [7:0] a);
    if (a == 8'h12) return m_i2;
    if (a == 8'h13) return m_sum();
    if (a >= 8'h14 && a <= 8'h17) return m_stat[a - 8'h14];
    if (a >= 8'h18 && a <= 8'h1B) return m_mask[a - 8'h18];
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h12) return "R10 info";
    if (a == 8'h13) return "R8 summary";
    if (a >= 8'h14 && a <= 8'h17) return "R6 status";
    if (a >= 8'h18 && a <= 8'h1B) return "R8 mask";
    return "R11 unmapped";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 irq vs model", irq_n, (m_sum() == 0));
      chk(tag_of(addr), rdata, m_rd(addr));
    end
  end

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2; we = 1; addr = a; wdata = d;
    @(posedge clk); #2; we = 0; wdata = '0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(posedge clk); #3;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk); #2; rst_n = 1;
    #3;
    // R1 reset state
    for (int a = 8'h13; a <= 8'h1B; a++) begin peek(8'(a), d); chk("R1 reset reg", d, 0); end
    chk("R1 reset irq", irq_n, 1);

    // R2 rise latency
    @(posedge clk); #2; cond[16] = 1;
    @(posedge clk); @(posedge clk); #3;
    peek(8'h16, d); chk("R2 before third edge", d, 8'h00);
    @(posedge clk); #3;
    peek(8'h16, d); chk("R2 rise latched", d, 8'h01);
    chk("R8 masked no irq", irq_n, 1);

    // R8/R9 mask and summary
    wr(8'h1A, 8'h01);
    peek(8'h1A, d); chk("R8 mask readback", d, 8'h01);
    peek(8'h13, d); chk("R8 summary bit2", d, 8'h04);
    chk("R9 irq asserted", irq_n, 0);

    // R11 steady level does not re-latch
    wr(8'h16, 8'h01);
    peek(8'h16, d); chk("R11 cleared", d, 8'h00);
    chk("R9 irq released", irq_n, 1);
    wait_n(3);
    peek(8'h16, d); chk("R11 no relatch", d, 8'h00);

    // R6 per-bit clear
    @(posedge clk); #2; cond[18:17] = 2'b11;
    wait_n(4);
    peek(8'h16, d); chk("R6 two bits set", d, 8'h06);
    wr(8'h16, 8'h02);
    peek(8'h16, d); chk("R6 one bit cleared", d, 8'h04);
    wr(8'h16, 8'h00);
    peek(8'h16, d); chk("R6 zero write no effect", d, 8'h04);

    // R3 paired detect / clear
    @(posedge clk); #2; cond[8] = 1;
    wait_n(4);
    peek(8'h15, d); chk("R3 enter latched", d, 8'h01);
    wr(8'h15, 8'h01);
    @(posedge clk); #2; cond[8] = 0;
    wait_n(4);
    peek(8'h15, d); chk("R3 exit latched", d, 8'h10);

    // R4 double-edge
    @(posedge clk); #2; cond[0] = 1;
    wait_n(4);
    peek(8'h14, d); chk("R4 rise", d, 8'h01);
    wr(8'h14, 8'h01);
    peek(8'h14, d); chk("R4 cleared", d, 8'h00);
    @(posedge clk); #2; cond[0] = 0;
    wait_n(4);
    peek(8'h14, d); chk("R4 fall", d, 8'h01);

    // R5 event pulse
    @(posedge clk); #2; evt[29] = 1;
    @(posedge clk); #2; evt[29] = 0; #1;
    peek(8'h17, d); chk("R5 event latched", d, 8'h20);

    // R7 set beats clear
    @(posedge clk); #2; evt[29] = 1; we = 1; addr = 8'h17; wdata = 8'h20;
    @(posedge clk); #2; evt[29] = 0; we = 0; wdata = '0;
    peek(8'h17, d); chk("R7 set wins", d, 8'h20);
    wr(8'h17, 8'h20);
    peek(8'h17, d); chk("R6 event cleared", d, 8'h00);

    // R8 summary upper bits, register 4 source
    wr(8'h1B, 8'hFF);
    @(posedge clk); #2; evt[24] = 1;
    @(posedge clk); #2; evt[24] = 0;
    peek(8'h13, d); chk("R8 summary reg4 only", d, 8'h08);
    chk("R9 irq from reg4", irq_n, 0);

    // R10 live info
    @(posedge clk); #2; info = 8'hA5;
    @(posedge clk); #3;
    peek(8'h12, d); chk("R10 after one edge", d, 8'h00);
    @(posedge clk); #3;
    peek(8'h12, d); chk("R10 live value", d, 8'hA5);
    wr(8'h12, 8'h00);
    peek(8'h12, d); chk("R10 write ignored", d, 8'hA5);
    wr(8'h17, 8'h01);
    chk("R10 no interrupt", irq_n, 1);

    // R11 unmapped
    peek(8'h05, d); chk("R11 unmapped 05", d, 0);
    peek(8'h1C, d); chk("R11 unmapped 1C", d, 0);
    peek(8'hFF, d); chk("R11 unmapped FF", d, 0);

    wait_n(2);
    finish_run();
  end
endmodule